// File: doc/BRIEF.md
# Byte-Read Converter Result Register

This block holds the 10-bit result of a conversion engine so that a processor with an 8-bit data bus can read it as two bytes. The engine presents a result together with a one-cycle done strobe. The bus side reads one byte per read strobe, and a byte-select input picks the low or the high byte. The stored value can be placed right-aligned or left-aligned inside a 16-bit byte pair. Alignment is applied when the value is read, so changing the alignment control takes effect at once.

To keep both bytes from the same conversion, a read of the low byte freezes the stored value. The freeze lasts until the high byte is read. A completion that arrives while the value is frozen is discarded, but it still raises the completion flag. The interrupt request is the flag gated by an enable input. Software clears the flag by writing a one to it, or an interrupt acknowledge clears it.

Top module: `conv_result_reg`

## Requirements
- R1: After reset, both bytes read as 0x00, `flag_o` and `irq_o` are 0, and the register is not frozen.
- R2: With `left_adj_i`=0, the low byte (`rd_hi_i`=0) returns result bits [7:0] and the high byte (`rd_hi_i`=1) returns {6'b0, result[9:8]}.
- R3: With `left_adj_i`=1, the high byte returns result[9:2] and the low byte returns {result[1:0], 6'b0}. Reading only the high byte therefore gives the top 8 bits.
- R4: A change of `left_adj_i` changes the byte view of the stored value in the same cycle, without a new conversion.
- R5: When unfrozen, a `conv_done_i` pulse stores `conv_data_i` at that clock edge, and the new value is readable from the next cycle.
- R6: A low-byte read (`rd_i`=1, `rd_hi_i`=0) freezes the stored value. A completion in the same cycle as that read, or in any later cycle while frozen, is discarded.
- R7: A high-byte read (`rd_i`=1, `rd_hi_i`=1) ends the freeze. A completion in the same cycle as the high-byte read is stored.
- R8: `flag_o` is set on every completion, including a discarded one. A set wins over a clear in the same cycle.
- R9: When no completion occurs in the same cycle, `flag_o` is cleared by a `flag_clr_i` pulse or by an `irq_ack_i` pulse.
- R10: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R11: A high-byte read with no low-byte read before it does not freeze the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle completion strobe from the conversion engine |
| conv_data_i | input | 10 | Result from the conversion engine |
| left_adj_i | input | 1 | 1 selects left-aligned placement, 0 selects right-aligned |
| rd_i | input | 1 | Bus read strobe |
| rd_hi_i | input | 1 | Byte select for a read: 1 selects the high byte, 0 the low byte |
| rd_data_o | output | 8 | Selected byte (combinational) |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the completion flag |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- the stored value does not change while frozen;
- an unfrozen completion stores its data;
- a high-byte read always leaves the register unfrozen;
- every completion sets the flag, and a clear with no completion empties it;
- the zero padding in each alignment;
- the interrupt gating.

Only the bench scenarios can show the rest, because each depends on a chosen sequence of reads and completions:
- which conversion's bytes a reader gets across a freeze;
- that a discarded result never appears later;
- that a completion in the same cycle as a high-byte read is kept;
- that realignment applies to a value that is already stored.

// File: rtl/conv_result_pkg.sv
package conv_result_pkg;
  // Place a right-aligned result inside a pair of bytes.
  function automatic logic [15:0] align_pair(input logic [15:0] right_v,
                                             input logic left_v,
                                             input int unsigned shift);
    return left_v ? (right_v << shift) : right_v;
  endfunction
endpackage

// File: rtl/result_store.sv
module result_store #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [RES_W-1:0] value_o,
  output logic             locked_o
);
  logic [RES_W-1:0] value_q;
  logic             lock_q;
  logic             wr_en;

  // A low read freezes in its own cycle; a high read releases in its own cycle.
  assign wr_en = done_i && !rd_lo_i && (!lock_q || rd_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_en) value_q <= data_i;
      if (rd_hi_i)      lock_q <= 1'b0;
      else if (rd_lo_i) lock_q <= 1'b1;
    end
  end

  assign value_o  = value_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/byte_view.sv
module byte_view
  import conv_result_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [RES_W-1:0]  value_i,
  input  logic              left_adj_i,
  input  logic              hi_sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;
  localparam int unsigned SHIFT  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair_w;

  generate
    if (PAIR_W == 16) begin : g_pkg
      assign pair_w = align_pair(16'(value_i), left_adj_i, SHIFT);
    end else begin : g_gen
      assign pair_w = left_adj_i ? (PAIR_W'(value_i) << SHIFT) : PAIR_W'(value_i);
    end
  endgenerate

  assign byte_o = hi_sel_i ? pair_w[PAIR_W-1:BYTE_W] : pair_w[BYTE_W-1:0];
endmodule

// File: rtl/done_flag.sv
module done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set wins
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              left_adj_i,
  input  logic              rd_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  input  logic              irq_ack_i,
  output logic              flag_o,
  output logic              irq_o
);
  logic [RES_W-1:0] value_w;
  logic             lock_w;
  logic             rd_lo_w;
  logic             rd_hi_w;

  assign rd_lo_w = rd_i && !rd_hi_i;
  assign rd_hi_w = rd_i &&  rd_hi_i;

  result_store #(.RES_W(RES_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (conv_done_i),
    .data_i   (conv_data_i),
    .rd_lo_i  (rd_lo_w),
    .rd_hi_i  (rd_hi_w),
    .value_o  (value_w),
    .locked_o (lock_w)
  );

  byte_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
    .value_i    (value_w),
    .left_adj_i (left_adj_i),
    .hi_sel_i   (rd_hi_i),
    .byte_o     (rd_data_o)
  );

  done_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (conv_done_i),
    .clr_i  (flag_clr_i || irq_ack_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/conv_result_chk.sv
module conv_result_chk #(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              conv_done_i,
  input logic [RES_W-1:0]  conv_data_i,
  input logic              left_adj_i,
  input logic              rd_i,
  input logic              rd_hi_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              irq_en_i,
  input logic              flag_clr_i,
  input logic              irq_ack_i,
  input logic              flag_o,
  input logic              irq_o,
  input logic [RES_W-1:0]  value_w,
  input logic              lock_w
);
  localparam int unsigned PAIR_W = 2 * BYTE_W;

  p_right_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && rd_hi_i && !left_adj_i |-> rd_data_o[BYTE_W-1:RES_W-BYTE_W] == '0);

  p_left_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !rd_hi_i && left_adj_i |-> rd_data_o[PAIR_W-RES_W-1:0] == '0);

  p_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !lock_w && !(rd_i && !rd_hi_i) |=> value_w == $past(conv_data_i));

  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_w && !(rd_i && rd_hi_i) |=> $stable(value_w));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && rd_hi_i |=> !lock_w);

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> flag_o);

  p_flag_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i || irq_ack_i) && !conv_done_i |=> !flag_o);

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o && irq_en_i);
endmodule

bind conv_result_reg conv_result_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_done_i (conv_done_i),
  .conv_data_i (conv_data_i),
  .left_adj_i  (left_adj_i),
  .rd_i        (rd_i),
  .rd_hi_i     (rd_hi_i),
  .rd_data_o   (rd_data_o),
  .irq_en_i    (irq_en_i),
  .flag_clr_i  (flag_clr_i),
  .irq_ack_i   (irq_ack_i),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .value_w     (value_w),
  .lock_w      (lock_w)
);

// File: tb/tb_conv_result_reg.sv
`timescale 1ns/1ps
module tb_conv_result_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       conv_done_i = 1'b0;
  logic [9:0] conv_data_i = '0;
  logic       left_adj_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       rd_hi_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       irq_en_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       flag_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] got;

  always #5 clk_i = ~clk_i;

  conv_result_reg dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One cycle: drive strobes 2 ns after an edge, sample rd_data_o before the next edge,
  // then drop strobes 2 ns after that edge.
  task automatic step(input logic done, input logic [9:0] d, input logic rd, input logic hi,
                      input logic clr, input logic ack);
    conv_done_i = done; conv_data_i = d; rd_i = rd; rd_hi_i = hi;
    flag_clr_i = clr; irq_ack_i = ack;
    #2 got = rd_data_o;
    @(posedge clk_i); #2;
    conv_done_i = 1'b0; rd_i = 1'b0; flag_clr_i = 1'b0; irq_ack_i = 1'b0;
  endtask

  task automatic rd_byte(input logic hi);
    step(1'b0, '0, 1'b1, hi, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
    rd_byte(1'b0); check("R1 low", got, 8'h00);
    rd_byte(1'b1); check("R1 high", got, 8'h00);
  endtask

  task automatic t_right;
    left_adj_i = 1'b0;
    step(1'b1, 10'h2A5, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_byte(1'b0); check("R5 R2 low", got, 8'hA5);
    rd_byte(1'b1); check("R2 high", got, 8'h02);
  endtask

  task automatic t_left;
    left_adj_i = 1'b1;  // no new conversion
    rd_byte(1'b1); check("R3 R4 high", got, 8'hA9);
    rd_byte(1'b0); check("R3 R4 low", got, 8'h40);
    rd_byte(1'b1); check("R3 high again", got, 8'hA9);
    left_adj_i = 1'b0;
    rd_byte(1'b1); check("R4 back right", got, 8'h02);
  endtask

  task automatic t_lock;
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_byte(1'b0); check("R6 low", got, 8'hA5);
    step(1'b1, 10'h155, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 flag on dropped", flag_o, 1);
    rd_byte(1'b1); check("R6 high frozen", got, 8'h02);
    rd_byte(1'b0); check("R6 low frozen", got, 8'hA5);
    rd_byte(1'b1);
    // completion in the same cycle as a low read is dropped
    step(1'b1, 10'h0F0, 1'b1, 1'b0, 1'b0, 1'b0);
    rd_byte(1'b1); check("R6 same-cycle drop", got, 8'h02);
    step(1'b1, 10'h155, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_byte(1'b0); check("R7 unlocked store low", got, 8'h55);
    rd_byte(1'b1); check("R7 unlocked store high", got, 8'h01);
  endtask

  task automatic t_release_same;
    rd_byte(1'b0);
    step(1'b1, 10'h3FF, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7 old high on release", got, 8'h01);
    rd_byte(1'b0); check("R7 same-cycle store low", got, 8'hFF);
    rd_byte(1'b1); check("R7 same-cycle store high", got, 8'h03);
  endtask

  task automatic t_hi_only;
    rd_byte(1'b1);
    step(1'b1, 10'h1C3, 1'b0, 1'b0, 1'b0, 1'b0);
    rd_byte(1'b1); check("R11 high", got, 8'h01);
    rd_byte(1'b0); check("R11 low", got, 8'hC3);
    rd_byte(1'b1);
  endtask

  task automatic t_flag;
    irq_en_i = 1'b0;
    step(1'b1, 10'h001, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 irq gated off", irq_o, 0);
    irq_en_i = 1'b1; #1;
    check("R10 irq on", irq_o, 1);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 clr", flag_o, 0);
    check("R10 irq follows", irq_o, 0);
    step(1'b1, 10'h002, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 ack", flag_o, 0);
    step(1'b1, 10'h003, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R8 set wins", flag_o, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    t_reset;
    t_right;
    t_left;
    t_lock;
    t_release_same;
    t_hi_only;
    t_flag;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule